// File: doc/BRIEF.md
# Burst Bus Transfer Controller

This block carries out bus requests from several masters on a shared single-word slave bus. Each master owns a slot that holds one request. A request has a start byte address, a length in 32-bit words, a direction flag and a lock flag. An external arbiter looks at the pending slots and grants one of them per cycle. The controller then makes one slave access for the current word of the granted slot. It decodes the address to a slave select and updates that slot's address, remaining count and status from the slave's answer.

Because each slot keeps its own progress, a long burst can lose the grant between words and carry on later from where it stopped. Losing the grant this way is never treated as a failure. The controller also tells the arbiter which master granted a locked word in the previous cycle, so the arbiter can keep that master on the bus. Slaves answer in the same cycle with a status code and read data. The slave data path runs straight from the master side to the slave side and back.

Top module: `burst_xfer_ctrl`

## Requirements
- R1: Status codes are REQUEST=0, WAIT=1, OK=2, ERROR=3. An issue pulse on a slot whose status is OK or ERROR loads the request, and the slot reads REQUEST from the next cycle until it is first served.
- R2: A request moves `len` words. The words are accessed one per completed slave access, at the start address and then at steps of +4 bytes.
- R3: A slot that has been served but has not finished reads WAIT.
- R4: When the last word completes, the slot reads OK and its done output is high for exactly that one cycle. Both become visible in the cycle after the edge on which the word completed.
- R5: Byte addresses 0x00–0x7F select slave 0 (slv_vld bit 0) and 0x80–0xFF select slave 1 (slv_vld bit 1). At most one slave valid is high in any cycle.
- R6: A granted word whose address maps to no slave raises no slave valid and ends the request with ERROR and a done pulse.
- R7: A slave status of WAIT leaves the address and count unchanged, so the same word is accessed again when the slot is next granted.
- R8: A slave status of ERROR ends the request at once with ERROR. No later word of that request is accessed.
- R9: A slot in WAIT that is not granted keeps WAIT, its address and its count. It resumes at the saved word when granted again, and finishes OK if its slaves answer OK.
- R10: An issue pulse on a slot in REQUEST or WAIT is ignored and sets that master's protocol-error output. The output stays set until reset.
- R11: arb_lock_vld is high, with arb_lock_id naming the master, in the cycle after an edge on which a locked request's word was granted. Otherwise it is low.
- R12: A grant that names a slot in OK or ERROR raises no slave valid and changes no slot.
- R13: After reset every slot reads OK, and the done, protocol-error, pending and lock outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_issue | input | NM | Per-master request pulse |
| mst_addr | input | NM*AW | Per-master start byte address |
| mst_len | input | NM*LW | Per-master length in words |
| mst_write | input | NM | Per-master direction, 1 = write |
| mst_lock | input | NM | Per-master lock flag |
| mst_status | output | 2*NM | Per-master status code |
| mst_done | output | NM | Per-master one-cycle completion pulse |
| mst_proto_err | output | NM | Per-master sticky protocol error |
| arb_pending | output | NM | Slots in REQUEST or WAIT |
| arb_lock_vld | output | 1 | A locked word was granted on the last edge |
| arb_lock_id | output | IDW | Master of that locked word |
| gnt_vld | input | 1 | Arbiter grant valid |
| gnt_id | input | IDW | Granted master |
| wr_data | input | DW | Write data of the granted master's current word |
| rd_data | output | DW | Read data from the selected slave |
| word_ack | output | 1 | Current word completes on this edge |
| bus_addr | output | AW | Address of the granted slot's current word |
| bus_write | output | 1 | Direction of the granted slot |
| bus_wdata | output | DW | Write data toward the slaves |
| slv_vld | output | NS | One-hot slave access valid |
| slv_rdata | input | NS*DW | Per-slave read data |
| slv_stat | input | 2*NS | Per-slave status (WAIT, OK or ERROR) |

## Verification
The properties assume four things about the inputs. Lengths are at least one word. gnt_id names an existing master. Each slave answers only WAIT, OK or ERROR. The two slave windows do not overlap. The bench's arbiter model grants only pending slots, with one exception: a directed case forces a grant onto an idle slot. Every request length in the bench is at least one. Its memory models return only the three legal codes, and the error code comes back only for a single programmable address.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
  typedef enum logic [1:0] {
    ST_REQUEST = 2'd0,
    ST_WAIT    = 2'd1,
    ST_OK      = 2'd2,
    ST_ERROR   = 2'd3
  } bxc_status_e;
endpackage

// File: rtl/bxc_burst_slot.sv
module bxc_burst_slot
  import bxc_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] iss_addr,
  input  logic [LW-1:0] iss_len,
  input  logic          iss_write,
  input  logic          iss_lock,
  input  logic          step,
  input  bxc_status_e   step_res,
  output bxc_status_e   status,
  output logic [AW-1:0] cur_addr,
  output logic          is_write,
  output logic          is_lock,
  output logic          active,
  output logic          done,
  output logic          proto_err
);
  localparam logic [AW-1:0] WORD_BYTES = AW'(4);

  bxc_status_e   st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] rem_q, rem_d;
  logic          we_q, lk_q, done_q, done_d, perr_q, perr_d;
  logic          ld_en;

  assign active = (st_q == ST_REQUEST) || (st_q == ST_WAIT);
  assign ld_en  = issue && !active;

  // next state: load on a legal issue, otherwise advance on a served word
  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    done_d = 1'b0;
    perr_d = perr_q | (issue & active);
    if (ld_en) begin
      st_d   = ST_REQUEST;
      addr_d = iss_addr;
      rem_d  = iss_len;
    end else if (step && active) begin
      unique case (step_res)
        ST_ERROR: begin
          st_d   = ST_ERROR;
          done_d = 1'b1;
        end
        ST_OK: begin
          addr_d = addr_q + WORD_BYTES;
          rem_d  = rem_q - LW'(1);
          if (rem_q <= LW'(1)) begin
            st_d   = ST_OK;
            done_d = 1'b1;
          end else begin
            st_d = ST_WAIT;
          end
        end
        default: st_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OK;
      addr_q <= '0;
      rem_q  <= '0;
      we_q   <= 1'b0;
      lk_q   <= 1'b0;
      done_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      done_q <= done_d;
      perr_q <= perr_d;
      if (ld_en) begin
        we_q <= iss_write;
        lk_q <= iss_lock;
      end
    end
  end

  assign status    = st_q;
  assign cur_addr  = addr_q;
  assign is_write  = we_q;
  assign is_lock   = lk_q;
  assign done      = done_q;
  assign proto_err = perr_q;
endmodule

// File: rtl/bxc_addr_decode.sv
module bxc_addr_decode #(
  parameter int             AW       = 32,
  parameter int             NS       = 2,
  parameter logic [NS*AW-1:0] SLV_BASE = '0,
  parameter logic [NS*AW-1:0] SLV_SIZE = '0
) (
  input  logic [AW-1:0] addr,
  output logic [NS-1:0] hit
);
  for (genvar s = 0; s < NS; s++) begin : g_win
    logic [AW-1:0] offs;
    assign offs   = addr - SLV_BASE[s*AW +: AW];
    assign hit[s] = offs < SLV_SIZE[s*AW +: AW];
  end
endmodule

// File: rtl/bxc_lock_track.sv
module bxc_lock_track #(
  parameter int IDW = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           step_lock,
  input  logic [IDW-1:0] step_id,
  output logic           lock_vld,
  output logic [IDW-1:0] lock_id
);
  logic           vld_q, vld_d;
  logic [IDW-1:0] id_q, id_d;

  always_comb begin
    vld_d = step && step_lock;
    id_d  = vld_d ? step_id : id_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      id_q  <= '0;
    end else begin
      vld_q <= vld_d;
      id_q  <= id_d;
    end
  end

  assign lock_vld = vld_q;
  assign lock_id  = id_q;
endmodule

// File: rtl/burst_xfer_ctrl.sv
module burst_xfer_ctrl
  import bxc_pkg::*;
#(
  parameter int               NM       = 2,
  parameter int               NS       = 2,
  parameter int               AW       = 32,
  parameter int               DW       = 32,
  parameter int               LW       = 8,
  parameter int               IDW      = (NM > 1) ? $clog2(NM) : 1,
  parameter logic [NS*AW-1:0] SLV_BASE = {32'h0000_0080, 32'h0000_0000},
  parameter logic [NS*AW-1:0] SLV_SIZE = {32'h0000_0080, 32'h0000_0080}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NM-1:0]     mst_issue,
  input  logic [NM*AW-1:0]  mst_addr,
  input  logic [NM*LW-1:0]  mst_len,
  input  logic [NM-1:0]     mst_write,
  input  logic [NM-1:0]     mst_lock,
  output logic [2*NM-1:0]   mst_status,
  output logic [NM-1:0]     mst_done,
  output logic [NM-1:0]     mst_proto_err,
  output logic [NM-1:0]     arb_pending,
  output logic              arb_lock_vld,
  output logic [IDW-1:0]    arb_lock_id,
  input  logic              gnt_vld,
  input  logic [IDW-1:0]    gnt_id,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              word_ack,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_write,
  output logic [DW-1:0]     bus_wdata,
  output logic [NS-1:0]     slv_vld,
  input  logic [NS*DW-1:0]  slv_rdata,
  input  logic [2*NS-1:0]   slv_stat
);
  localparam int PADN = 1 << IDW;

  bxc_status_e   slot_st   [NM];
  logic [AW-1:0] slot_addr [NM];
  logic [NM-1:0] slot_we, slot_lk, slot_act, slot_step;
  logic [PADN-1:0] act_pad;
  logic          gnt_ok, sel_we, sel_lk, mapped;
  logic [AW-1:0] sel_addr;
  logic [NS-1:0] hit;
  bxc_status_e   res;

  assign act_pad = PADN'(slot_act);
  assign gnt_ok  = gnt_vld && act_pad[gnt_id];

  // per-master request slots
  for (genvar m = 0; m < NM; m++) begin : g_slot
    assign slot_step[m] = gnt_ok && (gnt_id == IDW'(m));
    bxc_burst_slot #(.AW(AW), .LW(LW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (mst_issue[m]),
      .iss_addr  (mst_addr[m*AW +: AW]),
      .iss_len   (mst_len[m*LW +: LW]),
      .iss_write (mst_write[m]),
      .iss_lock  (mst_lock[m]),
      .step      (slot_step[m]),
      .step_res  (res),
      .status    (slot_st[m]),
      .cur_addr  (slot_addr[m]),
      .is_write  (slot_we[m]),
      .is_lock   (slot_lk[m]),
      .active    (slot_act[m]),
      .done      (mst_done[m]),
      .proto_err (mst_proto_err[m])
    );
    assign mst_status[2*m +: 2] = slot_st[m];
  end

  // pick the granted slot's current word
  always_comb begin
    sel_addr = '0;
    sel_we   = 1'b0;
    sel_lk   = 1'b0;
    for (int m = 0; m < NM; m++) begin
      if (gnt_id == IDW'(m)) begin
        sel_addr = slot_addr[m];
        sel_we   = slot_we[m];
        sel_lk   = slot_lk[m];
      end
    end
  end

  bxc_addr_decode #(
    .AW(AW), .NS(NS), .SLV_BASE(SLV_BASE), .SLV_SIZE(SLV_SIZE)
  ) u_dec (
    .addr (sel_addr),
    .hit  (hit)
  );

  assign mapped = |hit;

  // slave answer of the selected window, unmapped words fail
  always_comb begin
    res     = mapped ? ST_WAIT : ST_ERROR;
    rd_data = '0;
    for (int s = 0; s < NS; s++) begin
      if (hit[s]) begin
        res     = bxc_status_e'(slv_stat[2*s +: 2]);
        rd_data = slv_rdata[s*DW +: DW];
      end
    end
  end

  bxc_lock_track #(.IDW(IDW)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (gnt_ok),
    .step_lock (sel_lk),
    .step_id   (gnt_id),
    .lock_vld  (arb_lock_vld),
    .lock_id   (arb_lock_id)
  );

  assign slv_vld     = gnt_ok ? hit : '0;
  assign word_ack    = gnt_ok && mapped && (res == ST_OK);
  assign bus_addr    = sel_addr;
  assign bus_write   = sel_we;
  assign bus_wdata   = wr_data;
  assign arb_pending = slot_act;
endmodule

// File: rtl/burst_xfer_ctrl_chk.sv
module burst_xfer_ctrl_chk #(
  parameter int NM  = 2,
  parameter int NS  = 2,
  parameter int IDW = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NM-1:0]   mst_issue,
  input logic [2*NM-1:0] mst_status,
  input logic [NM-1:0]   mst_done,
  input logic [NM-1:0]   mst_proto_err,
  input logic            arb_lock_vld,
  input logic [IDW-1:0]  arb_lock_id,
  input logic            gnt_vld,
  input logic [IDW-1:0]  gnt_id,
  input logic [NS-1:0]   slv_vld
);
  a_r5_one_slave: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slv_vld));

  a_r11_lock_follow: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lock_vld |-> ($past(gnt_vld) && (arb_lock_id == $past(gnt_id))));

  for (genvar i = 0; i < NM; i++) begin : g_m
    logic [1:0] st;
    logic       own_gnt;
    assign st      = mst_status[2*i +: 2];
    assign own_gnt = gnt_vld && (gnt_id == IDW'(i));

    // finished codes (OK, ERROR) both have bit 1 set
    a_r1_issue_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_issue[i] && st[1]) |=> (mst_status[2*i +: 2] == 2'd0));

    a_r4_done_final: assert property (@(posedge clk) disable iff (!rst_n)
      mst_done[i] |-> st[1]);

    a_r9_preempt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == 2'd1) && !own_gnt) |=> (mst_status[2*i +: 2] == 2'd1));

    a_r10_proto_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      mst_proto_err[i] |=> mst_proto_err[i]);

    a_r12_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (own_gnt && st[1]) |-> (slv_vld == '0));
  end
endmodule

bind burst_xfer_ctrl burst_xfer_ctrl_chk #(.NM(NM), .NS(NS), .IDW(IDW)) u_chk (.*);

// File: tb/burst_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module burst_xfer_ctrl_bench;
  import bxc_pkg::*;

  localparam int NM = 2, NS = 2, AW = 32, DW = 32, LW = 8, IDW = 1;

  logic              clk, rst_n;
  logic [NM-1:0]     mst_issue, mst_write, mst_lock;
  logic [NM*AW-1:0]  mst_addr;
  logic [NM*LW-1:0]  mst_len;
  logic [2*NM-1:0]   mst_status;
  logic [NM-1:0]     mst_done, mst_proto_err, arb_pending;
  logic              arb_lock_vld, gnt_vld, word_ack, bus_write;
  logic [IDW-1:0]    arb_lock_id, gnt_id;
  logic [DW-1:0]     wr_data, rd_data, bus_wdata;
  logic [AW-1:0]     bus_addr;
  logic [NS-1:0]     slv_vld;
  logic [NS*DW-1:0]  slv_rdata;
  logic [2*NS-1:0]   slv_stat;

  logic [15:0] seed_q [NM];
  logic [31:0] err_addr;
  logic        force_gnt;
  logic        force_id;
  logic [31:0] mem  [64];
  logic [31:0] rbuf [64];
  logic        slow_waited;
  logic [1:0]  s0_st, s1_st, cur_st;
  int          nchk, nfail;

  burst_xfer_ctrl u_burst_xfer_ctrl (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // arbiter model: lock holder first, then lowest index
  always_comb begin
    gnt_vld = 1'b0;
    gnt_id  = '0;
    if (force_gnt) begin
      gnt_vld = 1'b1;
      gnt_id  = force_id;
    end else if (arb_lock_vld && arb_pending[arb_lock_id]) begin
      gnt_vld = 1'b1;
      gnt_id  = arb_lock_id;
    end else if (arb_pending[0]) begin
      gnt_vld = 1'b1;
      gnt_id  = 1'b0;
    end else if (arb_pending[1]) begin
      gnt_vld = 1'b1;
      gnt_id  = 1'b1;
    end
  end

  // slave models: window 0 answers at once, window 1 waits one cycle
  always_comb begin
    s0_st  = (bus_addr == err_addr) ? ST_ERROR : ST_OK;
    s1_st  = (bus_addr == err_addr) ? ST_ERROR : (slow_waited ? ST_OK : ST_WAIT);
    cur_st = slv_vld[1] ? s1_st : s0_st;
  end
  assign slv_stat  = {s1_st, s0_st};
  assign slv_rdata = {mem[bus_addr[7:2]], mem[bus_addr[7:2]]};
  assign wr_data   = {seed_q[gnt_id], bus_addr[15:0]};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_waited <= 1'b0;
      for (int k = 0; k < 64; k++) begin
        mem[k]  <= '0;
        rbuf[k] <= '0;
      end
    end else begin
      slow_waited <= slv_vld[1] && (s1_st == ST_WAIT);
      if ((|slv_vld) && bus_write && (cur_st == ST_OK)) mem[bus_addr[7:2]] <= bus_wdata;
      if (word_ack && !bus_write) rbuf[bus_addr[7:2]] <= rd_data;
    end
  end

  typedef struct packed {
    logic        m;
    logic [15:0] addr;
    logic [7:0]  len;
    logic        wr;
    logic [15:0] seed;
    logic [1:0]  st;
    logic [7:0]  lat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0000, 8'd4, 1'b1, 16'hA001, 2'd2, 8'd4},
    '{1'b1, 16'h0000, 8'd4, 1'b0, 16'hA001, 2'd2, 8'd4},
    '{1'b1, 16'h0080, 8'd2, 1'b1, 16'hB002, 2'd2, 8'd4},
    '{1'b0, 16'h0080, 8'd2, 1'b0, 16'hB002, 2'd2, 8'd4},
    '{1'b0, 16'h0078, 8'd4, 1'b1, 16'hC003, 2'd2, 8'd6},
    '{1'b1, 16'h0078, 8'd4, 1'b0, 16'hC003, 2'd2, 8'd6},
    '{1'b0, 16'h00FC, 8'd2, 1'b1, 16'hD004, 2'd3, 8'd3},
    '{1'b1, 16'h0200, 8'd1, 1'b0, 16'h0000, 2'd3, 8'd1},
    '{1'b0, 16'h00FC, 8'd1, 1'b0, 16'hD004, 2'd2, 8'd2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] st_of(input int m);
    return mst_status[2*m +: 2];
  endfunction

  task automatic issue(input int m, input logic [31:0] a, input logic [7:0] n,
                       input logic w, input logic lk, input logic [15:0] sd);
    @(negedge clk);
    seed_q[m]          = sd;
    mst_addr[m*32 +: 32] = a;
    mst_len[m*8 +: 8]    = n;
    mst_write[m]       = w;
    mst_lock[m]        = lk;
    mst_issue[m]       = 1'b1;
    @(negedge clk);
    mst_issue[m]       = 1'b0;
  endtask

  task automatic wait_done(input int m, output int lat);
    lat = 0;
    while (!mst_done[m] && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    int l0, l1;
    logic [31:0] saved0, saved2, saved3;
    vec_t v;
    nchk = 0; nfail = 0;
    rst_n = 1'b0;
    mst_issue = '0; mst_write = '0; mst_lock = '0; mst_addr = '0; mst_len = '0;
    seed_q[0] = '0; seed_q[1] = '0;
    err_addr = 32'hFFFF_FFFF;
    force_gnt = 1'b0; force_id = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk(mst_status == 4'b1010, "R13", "status", 32'(mst_status), 32'hA);
    chk(mst_done == '0 && mst_proto_err == '0 && arb_pending == '0 && !arb_lock_vld,
        "R13", "flags", {mst_done, mst_proto_err, arb_pending, arb_lock_vld}, 32'h0);

    // vector table
    for (int r = 0; r < NV; r++) begin
      v = VECS[r];
      issue(int'(v.m), 32'(v.addr), v.len, v.wr, 1'b0, v.seed);
      wait_done(int'(v.m), l0);
      chk(st_of(int'(v.m)) == v.st, (v.st == 2'd2) ? "R4" : "R6", "final status",
          32'(st_of(int'(v.m))), 32'(v.st));
      chk(l0 == int'(v.lat), "R2", "latency", 32'(l0), 32'(v.lat));
      for (int k = 0; k < int'(v.len); k++) begin
        logic [31:0] a;
        a = 32'(v.addr) + 32'(4 * k);
        if (a < 32'h100) begin
          if (v.wr) chk(mem[a[7:2]] == {v.seed, a[15:0]}, "R2", "written word",
                        mem[a[7:2]], {v.seed, a[15:0]});
          else chk(rbuf[a[7:2]] == {v.seed, a[15:0]}, "R2", "read word",
                   rbuf[a[7:2]], {v.seed, a[15:0]});
        end
      end
      @(negedge clk);
      chk(mst_done == '0, "R4", "done single pulse", 32'(mst_done), 32'h0);
    end

    // R1 R3 R5 R7 slow window sequence
    issue(1, 32'h84, 8'd2, 1'b0, 1'b0, 16'h0);
    chk(st_of(1) == 2'd0, "R1", "status after issue", 32'(st_of(1)), 32'h0);
    chk(slv_vld == 2'b10, "R5", "slow select", 32'(slv_vld), 32'h2);
    @(negedge clk);
    chk(st_of(1) == 2'd1, "R3", "status while served", 32'(st_of(1)), 32'h1);
    chk(bus_addr == 32'h84, "R7", "word repeated", bus_addr, 32'h84);
    wait_done(1, l0);
    chk(l0 == 3 && st_of(1) == 2'd2, "R7", "slow finish latency", 32'(l0), 32'h3);
    issue(0, 32'h04, 8'd1, 1'b0, 1'b0, 16'h0);
    chk(slv_vld == 2'b01, "R5", "fast select", 32'(slv_vld), 32'h1);
    wait_done(0, l0);

    // R11 locked burst keeps the bus
    fork
      begin
        issue(1, 32'h20, 8'd4, 1'b1, 1'b1, 16'h5151);
        wait_done(1, l1);
      end
      begin
        @(negedge clk);
        issue(0, 32'h30, 8'd1, 1'b1, 1'b0, 16'h5252);
        chk(arb_lock_vld && arb_lock_id == 1'b1, "R11", "lock hint",
            {arb_lock_vld, 31'(arb_lock_id)}, 32'h8000_0001);
        wait_done(0, l0);
      end
    join
    chk(l1 == 4, "R11", "locked latency", 32'(l1), 32'h4);
    chk(l0 == 4, "R11", "waiter latency", 32'(l0), 32'h4);
    @(negedge clk);
    chk(!arb_lock_vld, "R11", "lock hint clear", 32'(arb_lock_vld), 32'h0);

    // R9 preemption of an unlocked burst
    fork
      begin
        issue(1, 32'h00, 8'd6, 1'b1, 1'b0, 16'h6161);
        wait_done(1, l1);
      end
      begin
        repeat (2) @(negedge clk);
        issue(0, 32'h60, 8'd2, 1'b1, 1'b0, 16'h6262);
        chk(st_of(1) == 2'd1, "R9", "preempted status", 32'(st_of(1)), 32'h1);
        wait_done(0, l0);
      end
    join
    chk(l0 == 2, "R9", "preemptor latency", 32'(l0), 32'h2);
    chk(l1 == 8 && st_of(1) == 2'd2, "R9", "resumed latency", 32'(l1), 32'h8);
    for (int k = 0; k < 6; k++)
      chk(mem[k] == {16'h6161, 16'(4 * k)}, "R9", "resumed data", mem[k], {16'h6161, 16'(4 * k)});
    chk(mem[25] == {16'h6262, 16'h0064}, "R9", "preemptor data", mem[25], {16'h6262, 16'h0064});

    // R10 issue while busy
    issue(1, 32'h88, 8'd4, 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    saved0 = mem[0];
    issue(1, 32'h00, 8'd1, 1'b1, 1'b0, 16'h7171);
    chk(mst_proto_err == 2'b10, "R10", "protocol error", 32'(mst_proto_err), 32'h2);
    wait_done(1, l0);
    chk(st_of(1) == 2'd2, "R10", "first request completes", 32'(st_of(1)), 32'h2);
    repeat (2) @(negedge clk);
    chk(mem[0] == saved0, "R10", "ignored write", mem[0], saved0);
    chk(mst_proto_err[1], "R10", "sticky", 32'(mst_proto_err), 32'h2);

    // R8 slave error mid burst
    err_addr = 32'h08;
    saved2 = mem[2];
    saved3 = mem[3];
    issue(0, 32'h00, 8'd4, 1'b1, 1'b0, 16'h8181);
    wait_done(0, l0);
    err_addr = 32'hFFFF_FFFF;
    chk(st_of(0) == 2'd3, "R8", "error status", 32'(st_of(0)), 32'h3);
    chk(l0 == 3, "R8", "error latency", 32'(l0), 32'h3);
    chk(mem[1] == {16'h8181, 16'h0004}, "R8", "word before error", mem[1], {16'h8181, 16'h0004});
    chk(mem[2] == saved2 && mem[3] == saved3, "R8", "no later word", mem[3], saved3);

    // R12 grant onto an idle slot
    @(negedge clk);
    force_gnt = 1'b1;
    force_id  = 1'b0;
    #1;
    chk(slv_vld == '0, "R12", "no slave access", 32'(slv_vld), 32'h0);
    @(negedge clk);
    chk(st_of(0) == 2'd3 && mst_done == '0, "R12", "slot unchanged", 32'(st_of(0)), 32'h3);
    force_gnt = 1'b0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule